// File: doc/BRIEF.md
# Seeded BCD Watchdog Down-Counter

This block is a four-digit packed BCD down-counter for a system supervisor. Once enabled and loaded with a non-zero value, it counts down by one hundredth of a second on every pulse of an external 10 ms tick. If the count reaches zero, it raises a sticky expiry flag. It can also request a reset pulse of fixed length. The count range runs from 00.01 s to 99.99 s.

Software reaches the block through a small register port. Writing a counter byte loads the live count and a seed copy at the same time. Reading a counter byte returns that byte of the current count, and the count then restarts from the seed. Periodic reads or writes therefore keep the alarm from firing. When counting is disabled, the two counter bytes act as plain 16-bit storage.

The request port is valid/ready. A request transfers on a rising edge where `req_valid_i` and `req_ready_o` are both high. The block drops ready only while its reset request is active. The requester must then hold the request stable until it transfers. Read data returns as a one-cycle response pulse without back-pressure.

Top module: `wdc_top`

## Requirements
- R1: After reset the count, seed, control bits and flag are all zero. `rst_req_o` and `rsp_valid_o` are low, and `req_ready_o` is high.
- R2: A write to address 0 loads count digits [7:0] (tenths, hundredths), and a write to address 1 loads count digits [15:8] (tens of seconds, seconds). Each write sets the same byte of the seed.
- R3: A read of address 0 or 1 returns that byte of the current count on `rsp_rdata_o`, with `rsp_valid_o` high in the cycle after the request transfers. The count then equals the seed.
- R4: With enable set (address 2, bit 1), each tick pulse lowers a non-zero count by one hundredth. The decrement borrows in BCD across all four digits, so 10.00 becomes 09.99.
- R5: When a decrement reaches 0000, the flag (address 3, bit 0) sets. The count then stays at 0000 on later ticks.
- R6: Writing the flag with bit 0 = 0 clears it. Writing it with bit 0 = 1 leaves it unchanged.
- R7: If reset-select (address 2, bit 0) is set at expiry, `rst_req_o` goes high for exactly PULSE_CYCLES cycles, starting the cycle after the expiring tick. `req_ready_o` stays low for those cycles.
- R8: A count written as 0000 with enable set never counts and never sets the flag.
- R9: With enable clear, ticks leave the count unchanged, and the two bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse every 10 ms |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready; low while the reset request is active |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | 0 count low, 1 count high, 2 control, 3 flag |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read transfers |
| rsp_rdata_o | output | 8 | Read data |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse. They also assume that request fields stay stable while `req_valid_i` is high and ready is low, and that written counter bytes are valid BCD. The bench drives ticks only as one-cycle strobes. Its tasks hold each request until it transfers, and every count value it writes uses digits from 0 to 9. It never places a tick in the same cycle as a counter access, so each expected count follows from the tick count alone.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int DIGITS = 4;
  localparam int CNT_W  = 4 * DIGITS;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CNT_LO = 2'd0,
    ADDR_CNT_HI = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_FLAG   = 2'd3
  } wdc_addr_e;

  localparam int CTRL_SEL_BIT = 0;
  localparam int CTRL_EN_BIT  = 1;
  localparam int FLAG_BIT     = 0;
endpackage

// File: rtl/wdc_bcd_dec.sv
module wdc_bcd_dec #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] dec_o,
  output logic         is_zero_o,
  output logic         hits_zero_o
);
  // borrow[d] is set when every digit below d is zero
  logic [DIGITS:0] borrow;
  assign borrow[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] dig;
    assign dig = val_i[4*d +: 4];
    assign dec_o[4*d +: 4] = !borrow[d] ? dig :
                             (dig == 4'd0) ? 4'd9 : dig - 4'd1;
    assign borrow[d+1] = borrow[d] && (dig == 4'd0);
  end

  assign is_zero_o   = borrow[DIGITS];
  assign hits_zero_o = (dec_o == '0);
endmodule

// File: rtl/wdc_pulse_timer.sv
module wdc_pulse_timer #(
  parameter int CYCLES = 16,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  logic [CW-1:0] remain_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                remain_q <= '0;
    else if (start_i)           remain_q <= CW'(CYCLES);
    else if (remain_q != '0)    remain_q <= remain_q - CW'(1);
  end

  assign active_o = (remain_q != '0);
endmodule

// File: rtl/wdc_top.sv
module wdc_top
  import wdc_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BYTE_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_rdata_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] cnt_q, seed_q, cnt_dec;
  logic             en_q, sel_q, flag_q;
  logic             cnt_zero, dec_zero;
  logic             pulse_active;
  logic             fire, cnt_access, wr_cnt, rd_cnt;
  logic             wr_ctrl, clr_flag, count_step, expire;
  logic             rsp_valid_q;
  logic [BYTE_W-1:0] rdata_q;

  assign req_ready_o = !pulse_active;
  assign fire        = req_valid_i && req_ready_o;
  assign cnt_access  = fire && (req_addr_i == ADDR_CNT_LO || req_addr_i == ADDR_CNT_HI);
  assign wr_cnt      = cnt_access && req_write_i;
  assign rd_cnt      = cnt_access && !req_write_i;
  assign wr_ctrl     = fire && req_write_i && (req_addr_i == ADDR_CTRL);
  assign clr_flag    = fire && req_write_i && (req_addr_i == ADDR_FLAG) && !req_wdata_i[FLAG_BIT];

  // a counter access in the same cycle takes precedence over the tick
  assign count_step  = tick_i && en_q && !cnt_zero && !cnt_access;
  assign expire      = count_step && dec_zero;

  wdc_bcd_dec #(.DIGITS(DIGITS)) u_dec (
    .val_i       (cnt_q),
    .dec_o       (cnt_dec),
    .is_zero_o   (cnt_zero),
    .hits_zero_o (dec_zero)
  );

  wdc_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (expire && sel_q),
    .active_o (pulse_active)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seed_q <= '0;
    end else if (wr_cnt) begin
      if (req_addr_i == ADDR_CNT_HI) begin
        cnt_q[CNT_W-1:BYTE_W]  <= req_wdata_i;
        seed_q[CNT_W-1:BYTE_W] <= req_wdata_i;
      end else begin
        cnt_q[BYTE_W-1:0]  <= req_wdata_i;
        seed_q[BYTE_W-1:0] <= req_wdata_i;
      end
    end else if (rd_cnt) begin
      cnt_q <= seed_q;
    end else if (count_step) begin
      cnt_q <= cnt_dec;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= req_wdata_i[CTRL_EN_BIT];
      sel_q <= req_wdata_i[CTRL_SEL_BIT];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (clr_flag) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= fire && !req_write_i;
      if (fire && !req_write_i) begin
        unique case (req_addr_i)
          ADDR_CNT_LO: rdata_q <= cnt_q[BYTE_W-1:0];
          ADDR_CNT_HI: rdata_q <= cnt_q[CNT_W-1:BYTE_W];
          ADDR_CTRL: begin
            rdata_q               <= '0;
            rdata_q[CTRL_EN_BIT]  <= en_q;
            rdata_q[CTRL_SEL_BIT] <= sel_q;
          end
          default: begin
            rdata_q           <= '0;
            rdata_q[FLAG_BIT] <= flag_q;
          end
        endcase
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign rst_req_o   = pulse_active;
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fire,
  input logic        req_write_i,
  input logic [1:0]  req_addr_i,
  input logic [7:0]  req_wdata_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rst_req_o,
  input logic [15:0] cnt_q,
  input logic        en_q,
  input logic        flag_q
);
  logic cnt_touch, flag_clear;
  assign cnt_touch  = fire && !req_addr_i[1];
  assign flag_clear = fire && req_write_i && (req_addr_i == 2'd3) && !req_wdata_i[0];

  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !req_write_i) |=> rsp_valid_o); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clear) |=> flag_q); // R6

  AST_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == 16'h0000 && !cnt_touch) |=> (cnt_q == 16'h0000)); // R5

  AST_ZERO_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == 16'h0000 && !flag_q) |=> !flag_q); // R8

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cnt_touch) |=> $stable(cnt_q)); // R9

  AST_NO_ACCESS_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !req_ready_o); // R7

  AST_PULSE_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> flag_q); // R7
endmodule

bind wdc_top wdc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fire        (fire),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rst_req_o   (rst_req_o),
  .cnt_q       (cnt_q),
  .en_q        (en_q),
  .flag_q      (flag_q)
);

// File: tb/wdc_top_tb.sv
module wdc_top_tb;
  localparam int PULSE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, rst_req;
  logic [7:0] rsp_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdc_top #(.PULSE_CYCLES(PULSE)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .rst_req_o   (rst_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 rsp_valid", {7'b0, rsp_valid}, 8'h01);
    d = rsp_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rst_req", {7'b0, rst_req}, 8'h00);
    check("R1 ready", {7'b0, req_ready}, 8'h01);
    check("R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);
    rd(2'd2, d); check("R1 ctrl", d, 8'h00);
    rd(2'd3, d); check("R1 flag", d, 8'h00);
    rd(2'd0, d); check("R1 count low", d, 8'h00);
    rd(2'd1, d); check("R1 count high", d, 8'h00);
  endtask

  task automatic t_storage();
    logic [7:0] d;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    ticks(3);
    rd(2'd0, d); check("R9 low storage", d, 8'h34);
    rd(2'd1, d); check("R9 high storage", d, 8'h12);
  endtask

  task automatic t_decrement();
    logic [7:0] d;
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    ticks(1);
    rd(2'd1, d); check("R4 borrow 10.00->09.99 high", d, 8'h09);
    rd(2'd0, d); check("R3 reload from seed low", d, 8'h00);
    ticks(2);
    rd(2'd0, d); check("R4 two steps low", d, 8'h98);
    wr(2'd1, 8'h05);
    ticks(1);
    rd(2'd0, d); check("R2 write loads count low", d, 8'h99);
    rd(2'd1, d); check("R2 seed high reload", d, 8'h05);
  endtask

  task automatic t_expiry();
    logic [7:0] d;
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h02);
    ticks(1);
    rd(2'd3, d); check("R5 flag before zero", d, 8'h00);
    ticks(1);
    rd(2'd3, d); check("R5 flag at zero", d, 8'h01);
    check("R7 no request with select clear", {7'b0, rst_req}, 8'h00);
    ticks(2);
    rd(2'd0, d); check("R5 count stays zero", d, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    wr(2'd3, 8'h01);
    rd(2'd3, d); check("R6 write 1 keeps set", d, 8'h01);
    wr(2'd3, 8'h00);
    rd(2'd3, d); check("R6 write 0 clears", d, 8'h00);
    wr(2'd3, 8'h01);
    rd(2'd3, d); check("R6 write 1 does not set", d, 8'h00);
  endtask

  task automatic t_zero();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    ticks(4);
    rd(2'd3, d); check("R8 zero load no flag", d, 8'h00);
    rd(2'd0, d); check("R8 zero load stays", d, 8'h00);
  endtask

  task automatic t_pulse();
    logic [7:0] d;
    int n;
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    ticks(1);
    check("R7 request raised", {7'b0, rst_req}, 8'h01);
    check("R7 ready low", {7'b0, req_ready}, 8'h00);
    n = 0;
    while (rst_req && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R7 pulse length", n[7:0], 8'(PULSE));
    check("R7 ready back", {7'b0, req_ready}, 8'h01);
    rd(2'd3, d); check("R7 flag after pulse", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_decrement();
    t_expiry();
    t_sticky();
    t_zero();
    t_pulse();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule